// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key Queue

This block scans a key matrix of up to 64 switches. It drives one of eight scan rows at a time and reads eight return lines. Two extra inputs, shift and control, are sampled with every key. A key counts as pressed only when it reads down at two consecutive samples of its row. The scan rate sets the debounce window. Each accepted key is packed into one byte together with its shift and control state. The byte is queued in an eight-entry first-in first-out store.

The host talks to the block through a byte-wide command port. The top three bits of a command byte select the operation:
- set the keyboard mode (two-key lockout or N-key rollover),
- set the row dwell time,
- pop the oldest queued key into the read register,
- flush the queue,
- acknowledge the interrupt.

An interrupt output stays high while keys are waiting and have not been acknowledged. A sticky overrun output reports keys that were lost because the queue was full.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: After reset, `row_sel_o` is 8'h01, and `irq_o`, `overrun_o` and `rd_data` are all zero. The mode is two-key lockout and the dwell value is 3.
- R2: Exactly one row is driven at a time. Rows advance in ascending order (bit 0 up to bit 7, then back to bit 0). Each row is held for dwell+1 clock cycles. Command `001vvvvv` loads the dwell value `vvvvv`.
- R3: A key that is down at only one sample of its row is never queued.
- R4: A queued byte is laid out as bit 7 = control, bit 6 = shift, bits 5:3 = row index, bits 2:0 = column index. Shift and control are captured at the sample that accepts the key.
- R5: Lockout mode is selected by bit 0 = 0 of command `000xxxxm`. In this mode no new key is accepted while any accepted key is still held. Among keys that become ready together, the lower row wins, then the lower column. A blocked key that is still held is accepted after the held key is released.
- R6: Rollover mode is selected by bit 0 = 1. In this mode every pressed key is queued once. Keys ready in the same scan are queued in row order. Several keys in one row are queued one per scan, lowest column first.
- R7: Command `010xxxxx` moves the oldest entry into `rd_data`, with entries leaving in arrival order. `rd_data` is valid from the second cycle after the command. A pop on an empty queue leaves `rd_data` unchanged.
- R8: A key accepted while eight entries are queued is dropped and sets `overrun_o`. `overrun_o` stays set after the queue drains. The queued entries are not affected.
- R9: Command `110xxxxx` empties the queue and clears `overrun_o`, and `irq_o` falls.
- R10: `irq_o` is high while the queue is non-empty. Command `111xxxxx` forces it low without discarding entries, until the next key is stored.
- R11: Commands whose top bits are 011, 100 or 101 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_sel_o | output | ROWS (8) | One-hot scan row drive |
| col_in | input | COLS (8) | Return lines for the driven row, 1 = key down |
| shift_in | input | 1 | Shift key level |
| ctrl_in | input | 1 | Control key level |
| cmd_we | input | 1 | Command strobe, one cycle |
| cmd_byte | input | 8 | Command byte, opcode in bits 7:5 |
| rd_data | output | 8 | Last key popped from the queue |
| irq_o | output | 1 | Keys waiting and not acknowledged |
| overrun_o | output | 1 | Sticky lost-key flag |

## Verification
The bench drives a short press that one row sample can see but a second cannot. A design with no real debounce would queue that press. It presses two keys at once in lockout mode, both in the same row and in different rows. A priority encoder that is wrong, or that is missing, would queue the wrong key or both keys. It fills the queue past eight entries and checks that the ninth key is dropped while the first eight come back intact. A design that wraps its pointers would overwrite the oldest key. Acknowledge, flush, empty-pop and the unused opcodes are each checked at the interrupt and read outputs. This catches a design that discards data on acknowledge or decodes the display opcodes.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int CMD_W   = 8;
  localparam int DWELL_W = 5;

  typedef enum logic [2:0] {
    OP_MODE   = 3'b000,
    OP_TIMING = 3'b001,
    OP_READ   = 3'b010,
    OP_CLEAR  = 3'b110,
    OP_ACK    = 3'b111
  } kbd_op_e;
endpackage

// File: rtl/kbd_cmd.sv
module kbd_cmd
  import kbd_pkg::*;
#(
  parameter logic [DWELL_W-1:0] DWELL_RST = 5'd3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_we,
  input  logic [CMD_W-1:0]   cmd_byte,
  output logic               nkro,
  output logic [DWELL_W-1:0] dwell_lim,
  output logic               pop_stb,
  output logic               clr_stb,
  output logic               ack_stb
);
  logic [2:0] op;
  assign op = cmd_byte[CMD_W-1 -: 3];

  always_ff @(posedge clk) begin
    if (rst) begin
      nkro      <= 1'b0;
      dwell_lim <= DWELL_RST;
      pop_stb   <= 1'b0;
      clr_stb   <= 1'b0;
      ack_stb   <= 1'b0;
    end else begin
      pop_stb <= 1'b0;
      clr_stb <= 1'b0;
      ack_stb <= 1'b0;
      if (cmd_we) begin
        case (op)
          OP_MODE:   nkro      <= cmd_byte[0];
          OP_TIMING: dwell_lim <= cmd_byte[DWELL_W-1:0];
          OP_READ:   pop_stb   <= 1'b1;
          OP_CLEAR:  clr_stb   <= 1'b1;
          OP_ACK:    ack_stb   <= 1'b1;
          default:   ;
        endcase
      end
    end
  end

  // R11
  unused_op_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && (op == 3'b011 || op == 3'b100 || op == 3'b101))
      |=> !(pop_stb || clr_stb || ack_stb));
endmodule

// File: rtl/kbd_scan.sv
module kbd_scan
  import kbd_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nkro,
  input  logic [DWELL_W-1:0] dwell_lim,
  input  logic [COLS-1:0]    col_in,
  input  logic               shift_in,
  input  logic               ctrl_in,
  output logic [ROWS-1:0]    row_sel_o,
  output logic               push_o,
  output logic [1+1+$clog2(ROWS)+$clog2(COLS)-1:0] key_o
);
  localparam int ROW_W   = $clog2(ROWS);
  localparam int COL_W   = $clog2(COLS);

  logic [DWELL_W-1:0]         dwell_cnt;
  logic [ROW_W-1:0]           row_idx;
  logic [ROW_W-1:0]           row_nxt;
  logic [ROWS-1:0][COLS-1:0]  prev_q;
  logic [ROWS-1:0][COLS-1:0]  held_q;
  logic [COLS-1:0]            cand;
  logic [COLS-1:0]            pick_mask;
  logic [COL_W-1:0]           pick_col;
  logic                       pick_vld;
  logic                       sample;
  logic                       accept;

  assign sample  = dwell_cnt >= dwell_lim;
  assign row_nxt = (row_idx == ROW_W'(ROWS-1)) ? '0 : row_idx + 1'b1;

  always_comb begin
    cand     = col_in & prev_q[row_idx] & ~held_q[row_idx];
    pick_vld = 1'b0;
    pick_col = '0;
    for (int c = COLS-1; c >= 0; c--) begin
      if (cand[c]) begin
        pick_vld = 1'b1;
        pick_col = COL_W'(c);
      end
    end
  end

  assign accept    = sample && pick_vld && (nkro || !(|held_q));
  assign pick_mask = accept ? (COLS'(1) << pick_col) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dwell_cnt <= '0;
      row_idx   <= '0;
      row_sel_o <= ROWS'(1);
      prev_q    <= '0;
      held_q    <= '0;
      push_o    <= 1'b0;
      key_o     <= '0;
    end else begin
      push_o <= 1'b0;
      if (sample) begin
        dwell_cnt        <= '0;
        row_idx          <= row_nxt;
        row_sel_o        <= ROWS'(1) << row_nxt;
        prev_q[row_idx]  <= col_in;
        held_q[row_idx]  <= (held_q[row_idx] & (col_in | prev_q[row_idx])) | pick_mask;
        push_o           <= accept;
        key_o            <= {ctrl_in, shift_in, row_idx, pick_col};
      end else begin
        dwell_cnt <= dwell_cnt + 1'b1;
      end
    end
  end

  // R2
  row_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(row_sel_o));

  // R2
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_sel_o) |->
      row_sel_o == {$past(row_sel_o[ROWS-2:0]), $past(row_sel_o[ROWS-1])});

  // R5
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (push_o && $past(!nkro)) |-> $past(held_q == '0));
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         clr,
  output logic [W-1:0] dout,
  output logic         empty_o,
  output logic         stored_o,
  output logic         overrun_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [CW-1:0] count;
  logic          full;
  logic          wr_ok;
  logic          rd_ok;

  assign full     = count == CW'(DEPTH);
  assign empty_o  = count == '0;
  assign wr_ok    = push && !full && !clr;
  assign rd_ok    = pop && !empty_o && !clr;
  assign stored_o = wr_ok;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      overrun_o <= 1'b0;
      dout      <= '0;
    end else if (clr) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) begin
        rptr <= rptr + 1'b1;
        dout <= mem[rptr];
      end
      count <= count + CW'(wr_ok) - CW'(rd_ok);
      if (push && full) overrun_o <= 1'b1;
    end
  end

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R8
  overrun_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_o) |-> $past(push && count == CW'(DEPTH)));

  // R8
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && count == CW'(DEPTH) && !pop && !clr) |=> count == CW'(DEPTH));
endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
  import kbd_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int DEPTH     = 8,
  parameter int DWELL_RST = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [ROWS-1:0]      row_sel_o,
  input  logic [COLS-1:0]      col_in,
  input  logic                 shift_in,
  input  logic                 ctrl_in,
  input  logic                 cmd_we,
  input  logic [CMD_W-1:0]     cmd_byte,
  output logic [2+$clog2(ROWS)+$clog2(COLS)-1:0] rd_data,
  output logic                 irq_o,
  output logic                 overrun_o
);
  localparam int ENTRY_W = 2 + $clog2(ROWS) + $clog2(COLS);

  logic               nkro;
  logic [DWELL_W-1:0] dwell_lim;
  logic               pop_stb;
  logic               clr_stb;
  logic               ack_stb;
  logic               push;
  logic [ENTRY_W-1:0] key;
  logic               fifo_empty;
  logic               stored;
  logic               ack_q;

  kbd_cmd #(.DWELL_RST(DWELL_W'(DWELL_RST))) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (cmd_we),
    .cmd_byte  (cmd_byte),
    .nkro      (nkro),
    .dwell_lim (dwell_lim),
    .pop_stb   (pop_stb),
    .clr_stb   (clr_stb),
    .ack_stb   (ack_stb)
  );

  kbd_scan #(.ROWS(ROWS), .COLS(COLS)) u_scan (
    .clk       (clk),
    .rst       (rst),
    .nkro      (nkro),
    .dwell_lim (dwell_lim),
    .col_in    (col_in),
    .shift_in  (shift_in),
    .ctrl_in   (ctrl_in),
    .row_sel_o (row_sel_o),
    .push_o    (push),
    .key_o     (key)
  );

  kbd_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .din       (key),
    .pop       (pop_stb),
    .clr       (clr_stb),
    .dout      (rd_data),
    .empty_o   (fifo_empty),
    .stored_o  (stored),
    .overrun_o (overrun_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (stored)       ack_q <= 1'b0;
      else if (ack_stb) ack_q <= 1'b1;
      irq_o <= !fifo_empty && !ack_q;
    end
  end

  // R9
  clear_irq_chk: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> ##1 !irq_o);

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(!fifo_empty));
endmodule

// File: tb/tb_kbd_matrix_scanner.sv
module tb_kbd_matrix_scanner;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0] row_sel;
  logic [7:0] col_in;
  logic       shift_in = 1'b0;
  logic       ctrl_in  = 1'b0;
  logic       cmd_we   = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] rd_data;
  logic       irq;
  logic       ovr;
  logic [7:0][7:0] kb = '0;

  int dwell  = 3;
  int n_chk  = 0;
  int n_fail = 0;

  kbd_matrix_scanner dut (
    .clk(clk), .rst(rst), .row_sel_o(row_sel), .col_in(col_in),
    .shift_in(shift_in), .ctrl_in(ctrl_in), .cmd_we(cmd_we),
    .cmd_byte(cmd_byte), .rd_data(rd_data), .irq_o(irq), .overrun_o(ovr)
  );

  always_comb begin
    col_in = '0;
    for (int r = 0; r < 8; r++) if (row_sel[r]) col_in |= kb[r];
  end

  // {row[2:0], col[2:0], shift, ctrl, expected byte}
  localparam logic [15:0] VEC [6] = '{
    {3'd0, 3'd0, 1'b0, 1'b0, 8'h00},
    {3'd7, 3'd7, 1'b0, 1'b0, 8'h3F},
    {3'd3, 3'd5, 1'b1, 1'b0, 8'h5D},
    {3'd5, 3'd2, 1'b0, 1'b1, 8'hAA},
    {3'd1, 3'd6, 1'b1, 1'b1, 8'hCE},
    {3'd6, 3'd1, 1'b0, 1'b0, 8'h31}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic scans(int n);
    repeat (n * 8 * (dwell + 1)) @(negedge clk);
  endtask

  task automatic sync_row0();
    @(negedge clk);
    while (row_sel !== 8'h01) @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] b);
    @(negedge clk);
    cmd_we   = 1'b1;
    cmd_byte = b;
    @(negedge clk);
    cmd_we   = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_key(output logic [7:0] v);
    cmd(8'h40);
    v = rd_data;
  endtask

  task automatic key_stroke(int r, int c);
    sync_row0();
    kb[r][c] = 1'b1;
    scans(3);
    kb[r][c] = 1'b0;
    scans(3);
  endtask

  task automatic measure_row(output int len, output logic step_ok);
    logic [7:0] prev;
    @(negedge clk);
    prev = row_sel;
    while (row_sel === prev) @(negedge clk);
    prev = row_sel;
    len  = 0;
    while (row_sel === prev) begin
      @(negedge clk);
      len++;
    end
    step_ok = (row_sel === {prev[6:0], prev[7]});
  endtask

  function automatic logic [7:0] enc(int r, int c);
    return {2'b00, 3'(r), 3'(c)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int         len;
    logic       ok;

    repeat (4) @(negedge clk);
    check("R1 row_sel", row_sel, 8'h01);
    check("R1 irq", irq, 0);
    check("R1 overrun", ovr, 0);
    check("R1 rd_data", rd_data, 8'h00);
    rst = 1'b0;

    // R2: dwell timing and row order
    measure_row(len, ok);
    check("R2 dwell default", len, 4);
    check("R2 row order", ok, 1);
    cmd(8'h25);
    dwell = 5;
    measure_row(len, ok);
    check("R2 dwell programmed", len, 6);
    check("R2 row order", ok, 1);
    cmd(8'h23);
    dwell = 3;

    // R4: encoding table
    for (int i = 0; i < 6; i++) begin
      shift_in = VEC[i][9];
      ctrl_in  = VEC[i][8];
      key_stroke(int'(VEC[i][15:13]), int'(VEC[i][12:10]));
      shift_in = 1'b0;
      ctrl_in  = 1'b0;
      check("R10 irq with key queued", irq, 1);
      read_key(v);
      check("R4 entry layout", v, VEC[i][7:0]);
      check("R10 irq after drain", irq, 0);
    end

    // R3: one-sample glitch
    sync_row0();
    kb[2][2] = 1'b1;
    repeat (20) @(negedge clk);
    kb[2][2] = 1'b0;
    scans(3);
    check("R3 glitch not queued", irq, 0);

    // R5: lockout, second key blocked while first held
    sync_row0();
    kb[1][1] = 1'b1;
    scans(3);
    sync_row0();
    kb[4][4] = 1'b1;
    scans(3);
    read_key(v);
    check("R5 first key", v, 8'h09);
    check("R5 second blocked", irq, 0);
    kb[1][1] = 1'b0;
    scans(3);
    check("R5 second after release irq", irq, 1);
    read_key(v);
    check("R5 second after release", v, 8'h24);
    kb[4][4] = 1'b0;
    scans(3);

    // R5: same-row tie and cross-row tie
    sync_row0();
    kb[2][3] = 1'b1;
    kb[2][6] = 1'b1;
    scans(4);
    read_key(v);
    check("R5 same row lowest column", v, 8'h13);
    check("R5 same row single entry", irq, 0);
    kb[2][3] = 1'b0;
    kb[2][6] = 1'b0;
    scans(3);
    sync_row0();
    kb[6][0] = 1'b1;
    kb[1][7] = 1'b1;
    scans(4);
    read_key(v);
    check("R5 lower row wins", v, 8'h0F);
    check("R5 cross row single entry", irq, 0);
    kb[6][0] = 1'b0;
    kb[1][7] = 1'b0;
    scans(3);

    // R6: rollover
    cmd(8'h01);
    sync_row0();
    kb[5][0] = 1'b1;
    kb[2][7] = 1'b1;
    scans(4);
    read_key(v);
    check("R6 row order first", v, 8'h17);
    read_key(v);
    check("R6 row order second", v, 8'h28);
    kb[5][0] = 1'b0;
    kb[2][7] = 1'b0;
    scans(3);
    sync_row0();
    kb[3][1] = 1'b1;
    kb[3][4] = 1'b1;
    scans(4);
    read_key(v);
    check("R6 same row first", v, 8'h19);
    read_key(v);
    check("R6 same row second", v, 8'h1C);
    check("R6 no extra entries", irq, 0);
    kb[3][1] = 1'b0;
    kb[3][4] = 1'b0;
    scans(3);
    sync_row0();
    kb[0][5] = 1'b1;
    scans(3);
    kb[7][2] = 1'b1;
    scans(3);
    read_key(v);
    check("R6 held key", v, 8'h05);
    read_key(v);
    check("R6 key during hold", v, 8'h3A);
    kb[0][5] = 1'b0;
    kb[7][2] = 1'b0;
    scans(3);

    // R8: overflow
    for (int i = 0; i < 9; i++) begin
      key_stroke(i % 8, (15 - i) % 8);
      if (i == 7) check("R8 no overrun at eight", ovr, 0);
    end
    check("R8 overrun set", ovr, 1);
    check("R10 irq full", irq, 1);
    for (int i = 0; i < 8; i++) begin
      read_key(v);
      check("R7 R8 order kept", v, enc(i % 8, (15 - i) % 8));
    end
    check("R10 irq drained", irq, 0);
    check("R8 overrun sticky", ovr, 1);

    // R7: pop when empty
    read_key(v);
    check("R7 empty pop unchanged", v, enc(7, 0));

    // R9: clear
    key_stroke(2, 5);
    check("R9 irq before clear", irq, 1);
    cmd(8'hC0);
    check("R9 irq after clear", irq, 0);
    check("R9 overrun cleared", ovr, 0);
    read_key(v);
    check("R9 queue empty after clear", v, enc(7, 0));
    key_stroke(4, 1);
    read_key(v);
    check("R9 queue usable after clear", v, 8'h21);

    // R10: acknowledge
    key_stroke(6, 6);
    check("R10 irq raised", irq, 1);
    cmd(8'hE0);
    check("R10 irq acknowledged", irq, 0);
    read_key(v);
    check("R10 entry kept after ack", v, 8'h36);
    key_stroke(1, 2);
    check("R10 new key re-raises", irq, 1);
    read_key(v);
    check("R10 new key value", v, 8'h0A);

    // R11: unused opcodes
    key_stroke(3, 3);
    cmd(8'h60);
    cmd(8'h80);
    cmd(8'hA0);
    check("R11 irq unchanged", irq, 1);
    check("R11 rd_data unchanged", rd_data, 8'h0A);
    check("R11 overrun unchanged", ovr, 0);
    read_key(v);
    check("R11 queue intact", v, 8'h1B);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule